// File: doc/BRIEF.md
# Storage-to-Storage Byte Move Engine

This block carries out one move-character instruction in the 6-byte storage-to-storage form. A start strobe presents the instruction. The block checks the opcode and reads the two base registers through a combinational register read port. It then forms a destination address and a source address, and copies between 1 and 256 bytes over a byte-wide storage port that uses a ready handshake.

The length byte holds the byte count minus one. Each operand field is a 4-bit base register number followed by a 12-bit displacement. The field nearer the opcode is the destination and the other field is the source. Each byte is read and then written before the next byte is read. Bytes are moved in rising address order. Because of this, operands that overlap give a defined result. For example, a destination one byte above the source repeats the first source byte across the whole destination.

A controller starts the block, watches `busy`, and treats the one-cycle `done` pulse as the end of the move.

Top module: `mvc_move_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are all low.
- R2: A start whose top instruction byte is not hex D2 is ignored. `busy` stays low and no storage access is made.
- R3: The effective address of an operand is the low 24 bits of the base register value plus the zero-extended 12-bit displacement, taken modulo 2^24. A base field of 0 contributes zero whatever register 0 holds. Instruction bits [31:28]/[27:16] give the destination base and displacement. Bits [15:12]/[11:0] give the source base and displacement.
- R4: Instruction bits [39:32] hold the count minus one, so exactly that value plus 1 bytes are written. A value of FF gives 256 bytes.
- R5: Byte k is read from source+k and written to destination+k. Both addresses wrap modulo 2^24, and accesses alternate read, write, read, write in rising k.
- R6: Overlapping operands follow byte-sequential semantics. With destination = source + 1, every destination byte equals the original first source byte.
- R7: `busy` rises in the cycle after an accepted start and stays high until the last write is accepted. `done` is then high for exactly one cycle, with `busy` low.
- R8: A start that arrives while `busy` is high is ignored. The move in progress finishes unchanged.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable.
- R10: The instruction D2FF 8001 7000 moves 256 bytes from R7+0 to R8+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction strobe |
| instr | input | 48 | Instruction: opcode, length, destination field, source field |
| rsel_dst | output | 4 | Register number for the destination base |
| rsel_src | output | 4 | Register number for the source base |
| rval_dst | input | 32 | Register contents for `rsel_dst` |
| rval_src | input | 32 | Register contents for `rsel_src` |
| mem_req | output | 1 | Storage access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Storage byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Access completes on a clock edge when high |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle end-of-move pulse |

## Verification
A wrong address register or a bad increment shows up at the first storage access of the affected byte. In practice that is within two accepted transfers of the fault. A count that is off by one shows up as an extra or missing write before `done`. A state machine that skips or repeats a phase breaks the read/write alternation on the port at once. The byte copy itself is confirmed against a bench model of the whole memory image after each move, so data corruption in an overlapping copy is found by the end of that instruction.

// File: rtl/mvc_pkg.sv
package mvc_pkg;
   typedef enum logic [1:0] {
      MV_IDLE  = 2'd0,
      MV_READ  = 2'd1,
      MV_WRITE = 2'd2
   } mv_state_t;
endpackage

// File: rtl/mvc_addr_gen.sv
module mvc_addr_gen #(
   parameter int ADDR_W       = 24,
   parameter int BASE_W       = 4,
   parameter int DISP_W       = 12,
   parameter bit ZERO_BASE_R0 = 1'b1
) (
   input  logic [BASE_W-1:0] base_id,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] base_term;

   generate
      if (ZERO_BASE_R0) begin : g_r0_zero
         assign base_term = (base_id == '0) ? '0 : base_val;
      end else begin : g_r0_plain
         logic unused_id;
         assign unused_id = ^base_id;
         assign base_term = base_val;
      end
   endgenerate

   assign addr = ADDR_W'(base_term + ADDR_W'(disp));
endmodule

// File: rtl/mvc_seq.sv
module mvc_seq
   import mvc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [LEN_W-1:0]  len_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ready,
   output logic              busy,
   output logic              done
);
   mv_state_t         state_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [7:0]        data_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MV_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         data_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            MV_IDLE: if (go) begin
               src_q   <= src_in;
               dst_q   <= dst_in;
               cnt_q   <= len_in;
               state_q <= MV_READ;
            end
            MV_READ: if (mem_ready) begin
               data_q  <= mem_rdata;
               state_q <= MV_WRITE;
            end
            MV_WRITE: if (mem_ready) begin
               if (cnt_q == '0) begin
                  state_q <= MV_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q   <= cnt_q - 1'b1;
                  src_q   <= src_q + 1'b1;
                  dst_q   <= dst_q + 1'b1;
                  state_q <= MV_READ;
               end
            end
            default: state_q <= MV_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q != MV_IDLE);
   assign mem_we    = (state_q == MV_WRITE);
   assign mem_addr  = (state_q == MV_WRITE) ? dst_q : src_q;
   assign mem_wdata = data_q;
   assign busy      = (state_q != MV_IDLE);
   assign done      = done_q;

   // R5: both pointers step by one after each accepted write
   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_WRITE && mem_ready && cnt_q != '0)
      |=> (src_q == ADDR_W'($past(src_q) + 1'b1)) && (dst_q == ADDR_W'($past(dst_q) + 1'b1)));

   // R5: a read is always followed by the write of that byte
   assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_READ && mem_ready) |=> (state_q == MV_WRITE));

   // R8: a running move never reloads its remaining count upward
   assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (cnt_q <= $past(cnt_q)));

   // R9: held request while the port stalls
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));
endmodule

// File: rtl/mvc_move_engine.sv
module mvc_move_engine #(
   parameter int         ADDR_W       = 24,
   parameter int         REG_W        = 32,
   parameter int         LEN_W        = 8,
   parameter int         BASE_W       = 4,
   parameter int         DISP_W       = 12,
   parameter int         OP_W         = 8,
   parameter logic [7:0] OPCODE       = 8'hD2,
   parameter bit         ZERO_BASE_R0 = 1'b1,
   localparam int        INSTR_W      = OP_W + LEN_W + 2 * (BASE_W + DISP_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   output logic [BASE_W-1:0]  rsel_dst,
   output logic [BASE_W-1:0]  rsel_src,
   input  logic [REG_W-1:0]   rval_dst,
   input  logic [REG_W-1:0]   rval_src,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [7:0]         mem_wdata,
   input  logic [7:0]         mem_rdata,
   input  logic               mem_ready,
   output logic               busy,
   output logic               done
);
   localparam int OP_LSB  = INSTR_W - OP_W;
   localparam int LEN_LSB = OP_LSB - LEN_W;
   localparam int FLD_W   = BASE_W + DISP_W;

   generate
      if (ADDR_W >= REG_W) begin : g_bad_addr
         $error("ADDR_W must be narrower than REG_W");
      end
      if (DISP_W >= ADDR_W) begin : g_bad_disp
         $error("DISP_W must be narrower than ADDR_W");
      end
      if (OP_W != 8) begin : g_bad_op
         $error("OP_W must be 8");
      end
   endgenerate

   logic [OP_W-1:0]   opcode;
   logic [LEN_W-1:0]  len_code;
   logic [BASE_W-1:0] base_f [2];
   logic [DISP_W-1:0] disp_f [2];
   logic [REG_W-1:0]  rval_f [2];
   logic [ADDR_W-1:0] eff_f  [2];
   logic              go;
   logic              unused_hi;

   assign opcode   = instr[OP_LSB +: OP_W];
   assign len_code = instr[LEN_LSB +: LEN_W];
   assign rval_f[0] = rval_dst;
   assign rval_f[1] = rval_src;
   assign unused_hi = ^{rval_dst[REG_W-1:ADDR_W], rval_src[REG_W-1:ADDR_W]};

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_opnd
         localparam int LSB = (1 - g) * FLD_W;
         assign base_f[g] = instr[LSB + DISP_W +: BASE_W];
         assign disp_f[g] = instr[LSB +: DISP_W];
         mvc_addr_gen #(
            .ADDR_W(ADDR_W), .BASE_W(BASE_W), .DISP_W(DISP_W),
            .ZERO_BASE_R0(ZERO_BASE_R0)
         ) u_agen (
            .base_id (base_f[g]),
            .base_val(rval_f[g][ADDR_W-1:0]),
            .disp    (disp_f[g]),
            .addr    (eff_f[g])
         );
      end
   endgenerate

   assign rsel_dst = base_f[0];
   assign rsel_src = base_f[1];
   assign go       = start && (opcode == OPCODE);

   mvc_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .dst_in   (eff_f[0]),
      .src_in   (eff_f[1]),
      .len_in   (len_code),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .mem_ready(mem_ready),
      .busy     (busy),
      .done     (done)
   );

   // R2: a foreign opcode leaves the engine idle
   assert_bad_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && opcode != OPCODE) |=> !busy);

   // R7: done is a single-cycle pulse with busy already low
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7: an accepted start raises busy on the next cycle
   assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go) |=> busy);
endmodule

// File: tb/mvc_move_engine_test.sv
module mvc_move_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [47:0] instr = '0;
   logic [3:0]  rsel_dst, rsel_src;
   logic [31:0] rval_dst, rval_src;
   logic        mem_req, mem_we, mem_ready, busy, done;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   logic [31:0] regs [16];
   logic [7:0]  mem  [4096];
   logic [7:0]  sh   [4096];
   int          stall_pct = 0;
   int          checks = 0, errors = 0, cyc = 0;
   int          wcnt = 0, rcnt = 0, bad_seq = 0;
   logic [23:0] exp_dst = '0, exp_src = '0;

   always #2.5 clk = ~clk;

   mvc_move_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .rsel_dst(rsel_dst), .rsel_src(rsel_src),
      .rval_dst(rval_dst), .rval_src(rval_src),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .done(done)
   );

   assign rval_dst  = regs[rsel_dst];
   assign rval_src  = regs[rsel_src];
   assign mem_rdata = mem[mem_addr[11:0]];

   initial mem_ready = 1'b0;
   always @(posedge clk) begin
      mem_ready <= ($urandom % 100) >= stall_pct;
      if (mem_req && mem_we && mem_ready) mem[mem_addr[11:0]] <= mem_wdata;
   end

   // transaction monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ready) begin
         if (mem_we) begin
            if (mem_addr != 24'(exp_dst + 24'(wcnt))) bad_seq++;
            if (rcnt != wcnt + 1) bad_seq++;
            wcnt++;
         end else begin
            if (mem_addr != 24'(exp_src + 24'(rcnt))) bad_seq++;
            if (rcnt != wcnt) bad_seq++;
            rcnt++;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] eff(input logic [3:0] b, input logic [11:0] d);
      logic [23:0] bv = (b == 4'd0) ? 24'd0 : regs[b][23:0];
      return 24'(bv + 24'(d));
   endfunction

   task automatic compare_mem(input string tag);
      int first = -1;
      for (int i = 0; i < 4096; i++)
         if (mem[i] !== sh[i] && first < 0) first = i;
      if (first < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, tag, mem[first], sh[first]);
   endtask

   task automatic run_move(input logic [47:0] ins, input logic [47:0] intruder,
                           input bit inject, input string tag);
      int n, wait_c;
      bit busy_ok;
      exp_dst = eff(ins[31:28], ins[27:16]);
      exp_src = eff(ins[15:12], ins[11:0]);
      n = int'(ins[39:32]) + 1;
      for (int k = 0; k < n; k++)
         sh[12'(exp_dst + 24'(k))] = sh[12'(exp_src + 24'(k))];
      wcnt = 0; rcnt = 0; bad_seq = 0;
      @(negedge clk);
      instr = ins; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R7 busy after start", busy, 1);
      busy_ok = 1'b1; wait_c = 0;
      while (done !== 1'b1 && wait_c < 4000) begin
         @(negedge clk);
         wait_c++;
         if (inject && wait_c == 4) begin instr = intruder; start = 1'b1; end
         if (inject && wait_c == 5) start = 1'b0;
         if (done !== 1'b1 && busy !== 1'b1) busy_ok = 1'b0;
      end
      check(busy_ok, "R7 busy held until last write", busy_ok, 1);
      check(done === 1'b1 && busy === 1'b0, "R7 done with busy low", {done, busy}, 2'b10);
      check(wcnt == n, {"R4 byte count ", tag}, wcnt, n);
      check(bad_seq == 0, {"R5 address order ", tag}, bad_seq, 0);
      @(negedge clk);
      check(done === 1'b0, "R7 done one cycle", done, 0);
      compare_mem({"R5 data ", tag});
   endtask

   initial begin
      logic [7:0] first_b;
      bit any;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) regs[i] = $urandom;
      for (int i = 0; i < 4096; i++) begin mem[i] = 8'($urandom); sh[i] = mem[i]; end
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && mem_we === 1'b0,
            "R1 reset outputs", {busy, done, mem_req, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && mem_req === 1'b0, "R1 idle after reset", {busy, mem_req}, 0);

      // R2: foreign opcode
      @(negedge clk);
      instr = 48'hD3_10_1200_2300; start = 1'b1;
      @(negedge clk);
      start = 1'b0; any = 1'b0;
      repeat (6) begin
         if (busy !== 1'b0 || mem_req !== 1'b0) any = 1'b1;
         @(negedge clk);
      end
      check(!any, "R2 foreign opcode ignored", any, 0);
      compare_mem("R2 memory untouched");

      // R10 / R6: the 256-byte overlap example
      regs[7] = 32'h0000_0100; regs[8] = 32'h0000_0100;
      first_b = mem[12'h100];
      run_move(48'hD2FF_8001_7000, 48'h0, 1'b0, "R10 example");
      any = 1'b0;
      for (int i = 12'h101; i <= 12'h200; i++) if (mem[i] !== first_b) any = 1'b1;
      check(!any, "R6 overlap replicates first byte", any, 0);

      // R3: base 0 ignores register 0; upper register bits ignored
      regs[0] = 32'h0000_0555; regs[5] = 32'h7F00_0400;
      run_move(48'hD2_07_0300_5010, 48'h0, 1'b0, "R3 base zero");
      check(mem[12'h300] === sh[12'h410], "R3 destination at displacement only",
            mem[12'h300], sh[12'h410]);

      // R4: single byte
      regs[2] = 32'h0000_0800; regs[3] = 32'h0000_0900;
      run_move(48'hD2_00_2010_3020, 48'h0, 1'b0, "R4 one byte");

      // R5: destination wraps past 2^24
      regs[4] = 32'h00FF_FFF0;
      run_move(48'hD2_07_400C_3000, 48'h0, 1'b0, "R5 wrap");

      // R9: heavy stalls
      stall_pct = 70;
      run_move(48'hD2_1F_2040_3100, 48'h0, 1'b0, "R9 stalled");

      // R8: start while busy is ignored
      stall_pct = 30;
      run_move(48'hD2_13_2200_3300, 48'hD2_FF_2000_3000, 1'b1, "R8 start while busy");

      // random mix
      for (int t = 0; t < 30; t++) begin
         logic [47:0] ins;
         stall_pct = int'($urandom % 60);
         for (int r = 1; r < 16; r++) regs[r] = {8'($urandom), 12'h0, 12'($urandom)};
         ins = {8'hD2, 8'($urandom), 4'($urandom), 12'($urandom), 4'($urandom), 12'($urandom)};
         run_move(ins, 48'h0, 1'b0, "random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule